// File: doc/BRIEF.md
# SPI Master Register Front End

This block is the register side of an SPI master. A processor reaches it over a simple 32-bit APB-style bus. The block stores the frame configuration, the divider for the serial clock, the peripheral select word, two FIFO thresholds and an interrupt mask. It reports status and fill levels. It also holds a transmit FIFO and a receive FIFO. A separate shift engine takes frames from the transmit FIFO, shifts them on the pins and returns received frames into the receive FIFO.

A single enable bit decides when configuration may change. While the enable bit is 1, the configuration registers are locked. Clearing the enable bit discards everything buffered in both FIFOs. Each threshold register accepts only values below the FIFO depth, so software can find the depth by writing rising values and reading each one back.

Top module: `spi_regfront`

## Requirements
- R1: After reset, the registers read as follows: offset 0x00 = 0x007, 0x08 = 0, 0x10 = 0, 0x14 = 0, 0x18 = 0, 0x1C = 0, 0x20 = 0, 0x24 = 0, 0x2C = 0xFF, and status 0x28 = 0x06.
- R2: The configuration register at 0x00 has this layout: bits [3:0] frame size minus one, [5:4] format, bit 6 phase, bit 7 polarity, [9:8] transfer mode. Its fields, together with the select word at 0x10 and the divider at 0x14, appear on the engine configuration outputs. Bit 0 of 0x08 is the enable bit.
- R3: While the enable bit is 1, writes to 0x00, 0x10 and 0x14 leave those registers unchanged.
- R4: A write to the threshold registers at 0x18 and 0x1C is kept only when the written value is below the FIFO depth. Otherwise the old value remains. These writes are not gated by the enable bit.
- R5: While enabled, a write to 0x60 pushes bits [FW-1:0] into the transmit FIFO. The engine receives the words in write order on tx_data/tx_valid, and consumes one with tx_pop. Offset 0x20 reports the number of entries in the transmit FIFO.
- R6: A read of 0x60 returns and removes the oldest word of the receive FIFO, which is filled by rx_push/rx_data. Offset 0x24 reports the number of entries. A read of an empty receive FIFO returns 0 and changes nothing.
- R7: A write to 0x60 while the transmit FIFO holds DEPTH words is discarded, even if the engine pops in the same cycle. It sets the sticky transmit-error status bit 5.
- R8: When the enable bit goes from 1 to 0, both FIFOs and the transmit-error flag clear in that same cycle. While the bit is 0, data writes and rx_push have no effect.
- R9: Status at 0x28 has these bits: bit 0 = eng_busy, 1 = transmit FIFO not full, 2 = transmit FIFO empty, 3 = receive FIFO not empty, 4 = receive FIFO full, 5 = transmit error, 6 = collision (always 0). All bits above 6 read as 0.
- R10: A push and a pop on the same FIFO in one cycle leave its level unchanged and keep the word order.
- R11: Offsets that are not in the map read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte offset of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| cfg_en | output | 1 | Enable bit |
| cfg_fsz_m1 | output | 4 | Frame size minus one |
| cfg_cpha | output | 1 | Clock phase |
| cfg_cpol | output | 1 | Clock polarity |
| cfg_tmode | output | 2 | Transfer mode |
| cfg_ssel | output | NSS | Peripheral select word |
| cfg_baud | output | BAUD_W | Serial clock divider |
| irq_mask | output | MASK_W | Interrupt mask register |
| eng_busy | input | 1 | Engine is shifting a frame |
| tx_valid | output | 1 | Transmit FIFO has a word |
| tx_data | output | FW | Oldest transmit word |
| tx_pop | input | 1 | Engine consumes the oldest transmit word |
| rx_push | input | 1 | Engine delivers a received frame |
| rx_data | input | FW | Received frame |

## Verification
Two pairs of functions can fall in the same cycle. A processor write to the data port can meet an engine pop of the transmit FIFO. A processor read of the data port can meet an engine delivery into the receive FIFO. The bench raises the engine strobe during the access phase of a data-port transfer. It does this with the FIFO empty, partly filled and full. It then judges the word returned, the word offered to the engine, the next level reading and the error bit against a queue model. The model uses one rule for this case: a push is accepted based on the level before the cycle.

// File: rtl/spi_regfront_pkg.sv
package spi_regfront_pkg;

    localparam logic [7:0] A_CTRL0 = 8'h00;
    localparam logic [7:0] A_ENBL  = 8'h08;
    localparam logic [7:0] A_SSEL  = 8'h10;
    localparam logic [7:0] A_BAUD  = 8'h14;
    localparam logic [7:0] A_TXTHR = 8'h18;
    localparam logic [7:0] A_RXTHR = 8'h1C;
    localparam logic [7:0] A_TXLVL = 8'h20;
    localparam logic [7:0] A_RXLVL = 8'h24;
    localparam logic [7:0] A_STAT  = 8'h28;
    localparam logic [7:0] A_MASK  = 8'h2C;
    localparam logic [7:0] A_DATA  = 8'h60;

    // frame configuration word, packed so that bit positions match the map
    typedef struct packed {
        logic [1:0] tmode;
        logic       cpol;
        logic       cpha;
        logic [1:0] fmt;
        logic [3:0] fsz_m1;
    } ctrl0_t;

    localparam ctrl0_t CTRL0_RST = '{tmode: 2'd0, cpol: 1'b0, cpha: 1'b0,
                                     fmt: 2'd0, fsz_m1: 4'd7};

    typedef struct packed {
        logic dcol;
        logic txerr;
        logic rx_full;
        logic rx_nempty;
        logic tx_empty;
        logic tx_nfull;
        logic busy;
    } stat_t;

    function automatic logic [31:0] stat_word(input stat_t s);
        return {25'd0, s};
    endfunction

endpackage

// File: rtl/srf_fifo.sv
module srf_fifo #(
    parameter  int W     = 16,
    parameter  int DEPTH = 16,
    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = empty ? '0 : mem[rptr];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= step(wptr);
            if (do_pop)  rptr <= step(rptr);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && !clr && do_push) mem[wptr] <= wdata;
    end

    // R5
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    // R10
    pushpop_level_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && push && pop && !full && !empty) |=> $stable(count));

    // R7
    full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && push && full && !pop) |=> (count == CW'(DEPTH)));

endmodule

// File: rtl/srf_cfg.sv
module srf_cfg
    import spi_regfront_pkg::*;
#(
    parameter  int DEPTH  = 16,
    parameter  int NSS    = 4,
    parameter  int BAUD_W = 16,
    parameter  int MASK_W = 8,
    localparam int TW     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [7:0]        addr,
    input  logic [31:0]       wdata,
    input  logic              ovf_set,
    output logic              en_q,
    output logic              en_next,
    output ctrl0_t            ctrl0_q,
    output logic [NSS-1:0]    ssel_q,
    output logic [BAUD_W-1:0] baud_q,
    output logic [TW-1:0]     txthr_q,
    output logic [TW-1:0]     rxthr_q,
    output logic [MASK_W-1:0] mask_q,
    output logic              txerr_q
);
    logic cfg_open;
    logic thr_ok;

    assign cfg_open = wr_en && !en_q;
    assign thr_ok   = (wdata < 32'(DEPTH));
    assign en_next  = (wr_en && addr == A_ENBL) ? wdata[0] : en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= 1'b0;
            ctrl0_q <= CTRL0_RST;
            ssel_q  <= '0;
            baud_q  <= '0;
            txthr_q <= '0;
            rxthr_q <= '0;
            mask_q  <= '1;
            txerr_q <= 1'b0;
        end else begin
            en_q <= en_next;
            if (cfg_open && addr == A_CTRL0) ctrl0_q <= ctrl0_t'(wdata[9:0]);
            if (cfg_open && addr == A_SSEL)  ssel_q  <= wdata[NSS-1:0];
            if (cfg_open && addr == A_BAUD)  baud_q  <= wdata[BAUD_W-1:0];
            if (wr_en && addr == A_TXTHR && thr_ok) txthr_q <= wdata[TW-1:0];
            if (wr_en && addr == A_RXTHR && thr_ok) rxthr_q <= wdata[TW-1:0];
            if (wr_en && addr == A_MASK) mask_q <= wdata[MASK_W-1:0];
            if (!en_next)     txerr_q <= 1'b0;
            else if (ovf_set) txerr_q <= 1'b1;
        end
    end

    // R3
    ctrl_locked_chk: assert property (@(posedge clk) disable iff (rst)
        (en_q && wr_en && addr == A_CTRL0) |=> $stable(ctrl0_q));

    // R3
    baud_locked_chk: assert property (@(posedge clk) disable iff (rst)
        (en_q && wr_en && addr == A_BAUD) |=> $stable(baud_q));

    // R4
    thr_range_chk: assert property (@(posedge clk) disable iff (rst)
        (txthr_q < TW'(DEPTH)) && (rxthr_q < TW'(DEPTH)));

endmodule

// File: rtl/spi_regfront.sv
module spi_regfront
    import spi_regfront_pkg::*;
#(
    parameter  int FW     = 16,
    parameter  int DEPTH  = 16,
    parameter  int NSS    = 4,
    parameter  int BAUD_W = 16,
    parameter  int MASK_W = 8,
    localparam int CW     = $clog2(DEPTH + 1),
    localparam int TW     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [7:0]        paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              cfg_en,
    output logic [3:0]        cfg_fsz_m1,
    output logic              cfg_cpha,
    output logic              cfg_cpol,
    output logic [1:0]        cfg_tmode,
    output logic [NSS-1:0]    cfg_ssel,
    output logic [BAUD_W-1:0] cfg_baud,
    output logic [MASK_W-1:0] irq_mask,
    input  logic              eng_busy,
    output logic              tx_valid,
    output logic [FW-1:0]     tx_data,
    input  logic              tx_pop,
    input  logic              rx_push,
    input  logic [FW-1:0]     rx_data
);
    logic              wr_en, rd_en, data_wr, data_rd;
    logic              en_q, en_next, txerr_q, ovf_set;
    ctrl0_t            ctrl0_q;
    logic [TW-1:0]     txthr_q, rxthr_q;
    logic [CW-1:0]     tx_cnt, rx_cnt;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic [FW-1:0]     rx_head;
    stat_t             stat;

    assign wr_en   = psel && penable && pwrite;
    assign rd_en   = psel && penable && !pwrite;
    assign data_wr = wr_en && (paddr == A_DATA);
    assign data_rd = rd_en && (paddr == A_DATA);
    assign ovf_set = data_wr && tx_full && en_q;

    srf_cfg #(.DEPTH(DEPTH), .NSS(NSS), .BAUD_W(BAUD_W), .MASK_W(MASK_W)) u_cfg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(paddr), .wdata(pwdata),
        .ovf_set(ovf_set), .en_q(en_q), .en_next(en_next), .ctrl0_q(ctrl0_q),
        .ssel_q(cfg_ssel), .baud_q(cfg_baud), .txthr_q(txthr_q),
        .rxthr_q(rxthr_q), .mask_q(irq_mask), .txerr_q(txerr_q)
    );

    srf_fifo #(.W(FW), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst(rst), .clr(!en_next), .push(data_wr),
        .wdata(pwdata[FW-1:0]), .pop(tx_pop), .rdata(tx_data),
        .count(tx_cnt), .full(tx_full), .empty(tx_empty)
    );

    srf_fifo #(.W(FW), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .clr(!en_next), .push(rx_push),
        .wdata(rx_data), .pop(data_rd), .rdata(rx_head),
        .count(rx_cnt), .full(rx_full), .empty(rx_empty)
    );

    assign cfg_en     = en_q;
    assign cfg_fsz_m1 = ctrl0_q.fsz_m1;
    assign cfg_cpha   = ctrl0_q.cpha;
    assign cfg_cpol   = ctrl0_q.cpol;
    assign cfg_tmode  = ctrl0_q.tmode;
    assign tx_valid   = !tx_empty;

    always_comb begin
        stat           = '0;
        stat.busy      = eng_busy;
        stat.tx_nfull  = !tx_full;
        stat.tx_empty  = tx_empty;
        stat.rx_nempty = !rx_empty;
        stat.rx_full   = rx_full;
        stat.txerr     = txerr_q;
        stat.dcol      = 1'b0;
    end

    always_comb begin
        prdata = '0;
        if (rd_en) begin
            case (paddr)
                A_CTRL0: prdata = 32'(ctrl0_q);
                A_ENBL:  prdata = 32'(en_q);
                A_SSEL:  prdata = 32'(cfg_ssel);
                A_BAUD:  prdata = 32'(cfg_baud);
                A_TXTHR: prdata = 32'(txthr_q);
                A_RXTHR: prdata = 32'(rxthr_q);
                A_TXLVL: prdata = 32'(tx_cnt);
                A_RXLVL: prdata = 32'(rx_cnt);
                A_STAT:  prdata = stat_word(stat);
                A_MASK:  prdata = 32'(irq_mask);
                A_DATA:  prdata = 32'(rx_head);
                default: prdata = '0;
            endcase
        end
    end

    // R8
    flush_chk: assert property (@(posedge clk) disable iff (rst)
        (en_q && !en_next) |=> (tx_cnt == '0 && rx_cnt == '0 && !txerr_q));

    // R8
    idle_empty_chk: assert property (@(posedge clk) disable iff (rst)
        !en_q |-> (!tx_valid && rx_empty));

endmodule

// File: tb/spi_regfront_tb.sv
module spi_regfront_tb;
    localparam int D = 16;

    logic        clk = 0, rst = 1;
    logic        psel = 0, penable = 0, pwrite = 0;
    logic [7:0]  paddr = 0;
    logic [31:0] pwdata = 0, prdata;
    logic        cfg_en, cfg_cpha, cfg_cpol;
    logic [3:0]  cfg_fsz_m1;
    logic [1:0]  cfg_tmode;
    logic [3:0]  cfg_ssel;
    logic [15:0] cfg_baud;
    logic [7:0]  irq_mask;
    logic        eng_busy = 0, tx_valid, tx_pop = 0, rx_push = 0;
    logic [15:0] tx_data, rx_data = 0;

    int checks = 0, failures = 0;
    bit done = 0;
    logic [15:0] txq[$];
    logic [15:0] rxq[$];
    logic m_en = 0, m_err = 0;
    logic [15:0] head_seen;
    logic        valid_seen;

    always #5 clk = ~clk;

    spi_regfront u_dut (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .cfg_en(cfg_en),
        .cfg_fsz_m1(cfg_fsz_m1), .cfg_cpha(cfg_cpha), .cfg_cpol(cfg_cpol),
        .cfg_tmode(cfg_tmode), .cfg_ssel(cfg_ssel), .cfg_baud(cfg_baud),
        .irq_mask(irq_mask), .eng_busy(eng_busy), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_pop(tx_pop), .rx_push(rx_push), .rx_data(rx_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_stat();
        return {25'd0, 1'b0, m_err, rxq.size() == D, rxq.size() != 0,
                txq.size() == 0, txq.size() != D, eng_busy};
    endfunction

    // one bus transfer; optional engine strobes during the access phase
    task automatic xfer(input logic w, input logic [7:0] a, input logic [31:0] d,
                        input logic tp, input logic rp, input logic [15:0] rv,
                        output logic [31:0] rd);
        psel = 1; penable = 0; pwrite = w; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1; tx_pop = tp; rx_push = rp; rx_data = rv;
        #1;
        rd = prdata; head_seen = tx_data; valid_seen = tx_valid;
        @(negedge clk);
        psel = 0; penable = 0; pwrite = 0; tx_pop = 0; rx_push = 0;
    endtask

    // model of one cycle: engine pop/push plus optional data-port push/pop
    task automatic model_cycle(input logic dw, input logic [15:0] dv, input logic dr,
                               input logic tp, input logic rp, input logic [15:0] rv);
        int tsz = txq.size();
        int rsz = rxq.size();
        if (!m_en) return;
        if (tp && tsz != 0) void'(txq.pop_front());
        if (dw) begin
            if (tsz < D) txq.push_back(dv);
            else m_err = 1;
        end
        if (dr && rsz != 0) void'(rxq.pop_front());
        if (rp && rsz < D) rxq.push_back(rv);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        logic [31:0] r;
        xfer(1, a, d, 0, 0, 0, r);
        if (a == 8'h60) model_cycle(1, d[15:0], 0, 0, 0, 0);
        if (a == 8'h08) begin
            m_en = d[0];
            if (!d[0]) begin txq.delete(); rxq.delete(); m_err = 0; end
        end
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] r;
        xfer(0, a, 0, 0, 0, 0, r);
        check(req, r, exp);
    endtask

    // data-port write, optionally with an engine pop in the same cycle (R10, R7)
    task automatic dw_pop(input logic [15:0] v, input logic tp);
        logic [31:0] r;
        logic [15:0] eh = (txq.size() != 0) ? txq[0] : 16'h0;
        logic ev = (txq.size() != 0);
        xfer(1, 8'h60, {16'h0, v}, tp, 0, 0, r);
        if (tp) begin
            check("R10 tx_valid at pop", {31'd0, valid_seen}, {31'd0, ev});
            if (ev) check("R5 tx order at pop", {16'd0, head_seen}, {16'd0, eh});
        end
        model_cycle(1, v, 0, tp, 0, 0);
    endtask

    // data-port read, optionally with an engine delivery in the same cycle (R6, R10)
    task automatic dr_push(input logic rp, input logic [15:0] rv);
        logic [31:0] r;
        logic [31:0] e = (rxq.size() != 0) ? {16'd0, rxq[0]} : 32'd0;
        xfer(0, 8'h60, 0, 0, rp, rv, r);
        check("R6 data read", r, e);
        model_cycle(0, 0, 1, 0, rp, rv);
    endtask

    task automatic eng(input logic tp, input logic rp, input logic [15:0] rv);
        logic [15:0] eh = (txq.size() != 0) ? txq[0] : 16'h0;
        logic ev = (txq.size() != 0);
        tx_pop = tp; rx_push = rp; rx_data = rv;
        #1;
        if (tp) begin
            check("R5 tx_valid", {31'd0, tx_valid}, {31'd0, ev});
            if (ev) check("R5 tx order", {16'd0, tx_data}, {16'd0, eh});
        end
        @(negedge clk);
        tx_pop = 0; rx_push = 0;
        model_cycle(0, 0, 0, tp, rp, rv);
    endtask

    task automatic levels(input string req);
        rd_chk(req, 8'h20, txq.size());
        rd_chk(req, 8'h24, rxq.size());
        rd_chk(req, 8'h28, exp_stat());
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int found;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1 reset values
        rd_chk("R1 ctrl0", 8'h00, 32'h007);
        rd_chk("R1 enable", 8'h08, 0);
        rd_chk("R1 ssel", 8'h10, 0);
        rd_chk("R1 baud", 8'h14, 0);
        rd_chk("R1 txthr", 8'h18, 0);
        rd_chk("R1 rxthr", 8'h1C, 0);
        rd_chk("R1 mask", 8'h2C, 32'hFF);
        rd_chk("R1 status", 8'h28, 32'h06);
        rd_chk("R1 txlvl", 8'h20, 0);
        rd_chk("R1 rxlvl", 8'h24, 0);

        // R2 configuration while disabled
        wr(8'h00, 32'h2CF); wr(8'h14, 32'h0010); wr(8'h10, 32'h4);
        rd_chk("R2 ctrl0 readback", 8'h00, 32'h2CF);
        check("R2 fsz", cfg_fsz_m1, 4'hF);
        check("R2 cpha/cpol", {cfg_cpol, cfg_cpha}, 2'b11);
        check("R2 tmode", cfg_tmode, 2'd2);
        check("R2 baud", cfg_baud, 16'h10);
        check("R2 ssel", cfg_ssel, 4'h4);
        wr(8'h2C, 32'h3C);
        check("R2 mask out", irq_mask, 8'h3C);

        // R8 disabled: data write and rx_push ignored
        wr(8'h60, 32'h1234);
        eng(0, 1, 16'h5555);
        rd_chk("R8 disabled txlvl", 8'h20, 0);
        rd_chk("R8 disabled rxlvl", 8'h24, 0);

        // R3 lock while enabled
        wr(8'h08, 1);
        check("R2 enable out", cfg_en, 1);
        wr(8'h00, 32'h007); wr(8'h14, 32'h99); wr(8'h10, 32'h1);
        rd_chk("R3 ctrl0 locked", 8'h00, 32'h2CF);
        rd_chk("R3 baud locked", 8'h14, 32'h10);
        rd_chk("R3 ssel locked", 8'h10, 32'h4);

        // R4 depth probe
        found = 0;
        for (int f = 1; f < 256; f++) begin
            logic [31:0] r;
            xfer(1, 8'h18, f, 0, 0, 0, r);
            xfer(0, 8'h18, 0, 0, 0, 0, r);
            if (r != f) begin found = f; break; end
        end
        check("R4 probed depth", found, D);
        rd_chk("R4 txthr kept", 8'h18, D - 1);
        wr(8'h1C, 5); wr(8'h1C, 20);
        rd_chk("R4 rxthr kept", 8'h1C, 5);

        // R6 empty read
        dr_push(0, 0);
        rd_chk("R11 unused offset", 8'h04, 0);
        rd_chk("R11 unused offset 0x5C", 8'h5C, 0);

        // R5 / R7 fill transmit FIFO
        for (int i = 0; i < D; i++) wr(8'h60, 32'hA000 + i);
        levels("R5 full levels");
        wr(8'h60, 32'hBEEF);
        levels("R7 overflow");
        dw_pop(16'hCAFE, 1);
        levels("R7 full push with pop");
        for (int i = 0; i < 4; i++) eng(1, 0, 0);
        levels("R5 after pops");

        // R9 busy
        eng_busy = 1;
        rd_chk("R9 busy", 8'h28, exp_stat());
        eng_busy = 0;

        // R6 receive path, fill to full
        for (int i = 0; i < D + 1; i++) eng(0, 1, 16'h7000 + i);
        levels("R9 rx full");
        dr_push(1, 16'h7777);
        levels("R10 rx pop+push at full");
        for (int i = 0; i < 3; i++) dr_push(0, 0);
        dr_push(1, 16'h6161);
        levels("R10 rx concurrent");

        // R8 flush
        wr(8'h08, 0);
        levels("R8 flush");
        check("R8 tx_valid after flush", tx_valid, 0);
        wr(8'h08, 1);

        // R10 concurrent on empty
        dw_pop(16'h0101, 1);
        dr_push(1, 16'h0202);
        levels("R10 empty concurrent");

        // random mix
        for (int it = 0; it < 600; it++) begin
            int op = $urandom % 7;
            logic [15:0] v = 16'($urandom);
            case (op)
                0, 1: dw_pop(v, 0);
                2:    dr_push(0, 0);
                3:    eng(1, 0, 0);
                4:    eng(0, 1, v);
                5:    dw_pop(v, 1);
                default: dr_push(1, v);
            endcase
            if (it % 25 == 24) levels("R10 random levels");
            if (it == 300) begin
                wr(8'h08, 0); wr(8'h08, 1);
                levels("R8 random flush");
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule